// File: doc/BRIEF.md
# Variable-Width Gated Timer/Counter

This block is one timer channel. Its count is held in two bytes. The high byte always uses all eight bits. The low byte is a prescaler whose active width is chosen at run time from 1 to 8 bits, so the whole counter is 9 to 16 bits long. Each count pulse adds one to the active part of the low byte. When the active low bits are all ones, the pulse carries into the high byte. When the whole active count goes from all ones back to zero, a sticky overflow flag is set. The time to overflow is 256 × 2^(width) count pulses, where width is the field value plus one.

A pulse is taken from one of two sources. In timer mode it is a one-cycle tick from an outside divider. In counter mode it is a falling edge on an asynchronous event pin, which the block first synchronizes. A run bit enables counting. A gate bit can also make counting depend on an outside level input, which lets software measure how long that input is high.

Software reaches four byte registers through a simple write-strobe and address bus; reads return the addressed register with no delay.
- **Shared control register.** It carries output-enable and width fields for two channels. The parameter `CHAN` picks which pair this instance decodes.
- **Mode/status register.**
- **Low byte and high byte** of the count.

Top module: `vwt_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x24, the mode register (address 1) reads 0x00, both count bytes (low at address 2, high at address 3) read 0x00, and `ovf_flag` and `pwm_oe` are 0.
- R2: The control field selected by `CHAN` (bits 2:0 for channel 0, bits 5:3 for channel 1) holds a value P. The low byte's bits P:0 form the active prescaler. After 2^(P+1) pulses it returns to zero in those bits and the high byte increments by one.
- R3: Low-byte bits above bit P are left unchanged by counting. Their value has no effect on when the active bits wrap.
- R4: A pulse taken while the high byte is 0xFF and the active low bits are all ones does three things at the next clock: it sets `ovf_flag` (also readable at mode bit 3), clears the active low bits and sets the high byte to 0x00.
- R5: A pulse is accepted only when mode bit 0 (run) is 1 and either mode bit 1 (gate) is 0 or `gate_pin` is 1. Otherwise both count bytes stay unchanged.
- R6: With mode bit 2 at 0 (timer mode), every clock in which `tick_in` is 1 and counting is enabled adds exactly one count.
- R7: With mode bit 2 at 1 (counter mode), each falling edge of `event_pin` adds exactly one count, seen within four clocks of the edge, and `tick_in` is ignored.
- R8: The overflow flag stays 1 until a mode-register write with bit 3 at 0 clears it. A write with bit 3 at 1 leaves it alone. If an overflow and a clearing write happen in the same cycle, the flag ends up 1.
- R9: A write to the low or high byte appears at the next clock. If a pulse falls in the same cycle, the written value replaces the result of the increment for that byte.
- R10: Changing run from 0 to 1 leaves the count bytes as they were.
- R11: `pwm_oe` follows control bit 6 for channel 0 (bit 7 for channel 1). The other channel's fields have no effect on this instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 mode, 2 low byte, 3 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| tick_in | input | 1 | One-cycle count tick used in timer mode |
| event_pin | input | 1 | Asynchronous event input; falling edges count in counter mode |
| gate_pin | input | 1 | External gate level, used when the gate bit is set |
| ovf_flag | output | 1 | Sticky overflow flag |
| pwm_oe | output | 1 | Output enable of the waveform pin for this channel |

## Verification
Two pairs of actions can land in the same clock.
- **Flag set against flag clear.** The counter is loaded one pulse short of overflow. A mode write with bit 3 at 0 is then issued in the very cycle that `tick_in` is high. The flag must read 1 afterwards.
- **Byte write against increment.** A low-byte write is issued while a tick is accepted. The byte must read back exactly the written value, not that value plus one and not the old value plus one.

// File: rtl/vwt_pkg.sv
package vwt_pkg;

    localparam int BYTE_W    = 8;
    localparam int PSC_W     = 3;
    localparam int ADDR_W    = 2;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h24;

    localparam int MODE_RUN_BIT  = 0;
    localparam int MODE_GATE_BIT = 1;
    localparam int MODE_SRC_BIT  = 2;
    localparam int MODE_OVF_BIT  = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_LOW  = 2'd2,
        ADDR_HIGH = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SRC_TICK  = 1'b0,
        SRC_EVENT = 1'b1
    } src_sel_e;

    typedef struct packed {
        src_sel_e src;
        logic     gate;
        logic     run;
    } mode_t;

    typedef struct packed {
        logic              wr_low;
        logic              wr_high;
        logic [BYTE_W-1:0] data;
    } cnt_wr_t;

    function automatic logic [BYTE_W-1:0] active_mask(input logic [PSC_W-1:0] psc);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = (i <= int'(psc));
        end
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] masked_inc(input logic [BYTE_W-1:0] val,
                                                     input logic [BYTE_W-1:0] mask);
        logic [BYTE_W-1:0] plus;
        plus = val + 1'b1;
        return (val & ~mask) | (plus & mask);
    endfunction

endpackage

// File: rtl/vwt_regs.sv
module vwt_regs
    import vwt_pkg::*;
#(
    parameter int CHAN = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  reg_addr_e         addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ovf_set,
    output logic [BYTE_W-1:0] ctrl_q,
    output mode_t             mode_q,
    output logic              ovf_q,
    output logic [PSC_W-1:0]  psc,
    output logic              pwm_oe,
    output cnt_wr_t           cnt_wr
);

    logic wr_ctrl, wr_mode, ovf_clear;

    assign wr_ctrl   = wen && (addr == ADDR_CTRL);
    assign wr_mode   = wen && (addr == ADDR_MODE);
    assign ovf_clear = wr_mode && !wdata[MODE_OVF_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q.run  <= wdata[MODE_RUN_BIT];
            mode_q.gate <= wdata[MODE_GATE_BIT];
            mode_q.src  <= src_sel_e'(wdata[MODE_SRC_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end else if (ovf_clear) begin
            ovf_q <= 1'b0;
        end
    end

    generate
        if (CHAN == 0) begin : g_chan0
            assign psc    = ctrl_q[PSC_W-1:0];
            assign pwm_oe = ctrl_q[BYTE_W-2];
        end else begin : g_chan1
            assign psc    = ctrl_q[2*PSC_W-1:PSC_W];
            assign pwm_oe = ctrl_q[BYTE_W-1];
        end
    endgenerate

    always_comb begin
        cnt_wr.wr_low  = wen && (addr == ADDR_LOW);
        cnt_wr.wr_high = wen && (addr == ADDR_HIGH);
        cnt_wr.data    = wdata;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_q); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(wen && addr == ADDR_MODE && !wdata[MODE_OVF_BIT])) |=> ovf_q); // R8

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wen && addr == ADDR_CTRL) |=> $stable(ctrl_q)); // R11

endmodule

// File: rtl/vwt_event_sync.sv
module vwt_event_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q && !sync_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R7

endmodule

// File: rtl/vwt_count_core.sv
module vwt_count_core
    import vwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PSC_W-1:0]  psc,
    input  logic              pulse,
    input  cnt_wr_t           cnt_wr,
    output logic [BYTE_W-1:0] low_q,
    output logic [BYTE_W-1:0] high_q,
    output logic              ovf_set
);

    logic [BYTE_W-1:0] mask;
    logic              wrap;
    logic [BYTE_W-1:0] low_next, high_next;

    assign mask    = active_mask(psc);
    assign wrap    = ((low_q & mask) == mask);
    assign ovf_set = pulse && wrap && (high_q == {BYTE_W{1'b1}});

    always_comb begin
        low_next  = low_q;
        high_next = high_q;
        if (pulse) begin
            low_next = masked_inc(low_q, mask);
            if (wrap) begin
                high_next = high_q + 1'b1;
            end
        end
        if (cnt_wr.wr_low) begin
            low_next = cnt_wr.data;
        end
        if (cnt_wr.wr_high) begin
            high_next = cnt_wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= '0;
            high_q <= '0;
        end else begin
            low_q  <= low_next;
            high_q <= high_next;
        end
    end

    AST_WRITE_WINS_LOW: assert property (@(posedge clk) disable iff (rst)
        cnt_wr.wr_low |=> low_q == $past(cnt_wr.data)); // R9

    AST_WRITE_WINS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cnt_wr.wr_high |=> high_q == $past(cnt_wr.data)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !cnt_wr.wr_low && !cnt_wr.wr_high) |=> ($stable(low_q) && $stable(high_q))); // R5

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pulse && !cnt_wr.wr_low) |=> (((low_q ^ $past(low_q)) & ~$past(mask)) == '0)); // R3

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ovf_set && !cnt_wr.wr_low && !cnt_wr.wr_high) |=> (high_q == '0 && ((low_q & $past(mask)) == '0))); // R4

endmodule

// File: rtl/vwt_timer.sv
module vwt_timer
    import vwt_pkg::*;
#(
    parameter int CHAN        = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_in,
    input  logic              event_pin,
    input  logic              gate_pin,
    output logic              ovf_flag,
    output logic              pwm_oe
);

    reg_addr_e         addr;
    logic [BYTE_W-1:0] ctrl_q, low_q, high_q;
    mode_t             mode_q;
    logic              ovf_q, ovf_set, event_fall, enable, pulse;
    logic [PSC_W-1:0]  psc;
    cnt_wr_t           cnt_wr;

    assign addr = reg_addr_e'(bus_addr);

    vwt_regs #(.CHAN(CHAN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wen     (bus_wen),
        .addr    (addr),
        .wdata   (bus_wdata),
        .ovf_set (ovf_set),
        .ctrl_q  (ctrl_q),
        .mode_q  (mode_q),
        .ovf_q   (ovf_q),
        .psc     (psc),
        .pwm_oe  (pwm_oe),
        .cnt_wr  (cnt_wr)
    );

    vwt_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (event_pin),
        .fall (event_fall)
    );

    assign enable = mode_q.run && (!mode_q.gate || gate_pin);

    always_comb begin
        unique case (mode_q.src)
            SRC_EVENT: pulse = enable && event_fall;
            default:   pulse = enable && tick_in;
        endcase
    end

    vwt_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .psc     (psc),
        .pulse   (pulse),
        .cnt_wr  (cnt_wr),
        .low_q   (low_q),
        .high_q  (high_q),
        .ovf_set (ovf_set)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_MODE: bus_rdata = {4'b0000, ovf_q, mode_q.src, mode_q.gate, mode_q.run};
            ADDR_LOW:  bus_rdata = low_q;
            default:   bus_rdata = high_q;
        endcase
    end

    assign ovf_flag = ovf_q;

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.run && !bus_wen) |=> ($stable(low_q) && $stable(high_q))); // R5

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (mode_q.gate && !gate_pin && !bus_wen) |=> ($stable(low_q) && $stable(high_q))); // R5

    AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode_q.src == SRC_EVENT && !event_fall && !bus_wen) |=> ($stable(low_q) && $stable(high_q))); // R7

endmodule

// File: tb/vwt_timer_tb.sv
module vwt_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wen = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0;
    logic       event_pin = 1'b1;
    logic       gate_pin = 1'b0;
    logic       ovf_flag;
    logic       pwm_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    vwt_timer #(.CHAN(0)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_in   (tick_in),
        .event_pin (event_pin),
        .gate_pin  (gate_pin),
        .ovf_flag  (ovf_flag),
        .pwm_oe    (pwm_oe)
    );

    // Monitor: pops expected items and compares them with the design output
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            if (it.sel < 4)       act = bus_rdata;
            else if (it.sel == 4) act = {7'd0, ovf_flag};
            else                  act = {7'd0, pwm_oe};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // Driver: sel 0..3 register address, 4 ovf_flag, 5 pwm_oe
    task automatic expect_val(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        if (sel < 4) bus_addr = 2'(sel);
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic with_tick);
        @(posedge clk); #1;
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d; tick_in = with_tick;
        @(posedge clk); #1;
        bus_wen = 1'b0; tick_in = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_in = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_in = 1'b0;
    endtask

    task automatic event_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (3) @(posedge clk);
            #1 event_pin = 1'b0;
            repeat (3) @(posedge clk);
            #1 event_pin = 1'b1;
        end
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_val(0, 8'h24, "R1 ctrl");
        expect_val(1, 8'h00, "R1 mode");
        expect_val(2, 8'h00, "R1 low");
        expect_val(3, 8'h00, "R1 high");
        expect_val(4, 8'h00, "R1 ovf");
        expect_val(5, 8'h00, "R1 pwm");

        // R2 / R6: default 5-bit prescaler
        bus_write(2'd1, 8'h01, 1'b0);
        ticks(31);
        expect_val(2, 8'h1F, "R6 low after 31 ticks");
        expect_val(3, 8'h00, "R2 high before wrap");
        ticks(1);
        expect_val(2, 8'h00, "R2 low wraps");
        expect_val(3, 8'h01, "R2 high carry");

        // R5 run=0 blocks, R10 run set keeps count
        bus_write(2'd1, 8'h00, 1'b0);
        ticks(3);
        expect_val(2, 8'h00, "R5 stopped low");
        bus_write(2'd1, 8'h01, 1'b0);
        expect_val(3, 8'h01, "R10 high kept");
        expect_val(2, 8'h00, "R10 low kept");

        // R3 upper bits preserved and ignored (2-bit prescaler)
        bus_write(2'd0, 8'h21, 1'b0);
        bus_write(2'd2, 8'hA3, 1'b0);
        bus_write(2'd3, 8'h10, 1'b0);
        ticks(1);
        expect_val(2, 8'hA0, "R3 low wrap keeps upper");
        expect_val(3, 8'h11, "R3 high carry");
        ticks(2);
        expect_val(2, 8'hA2, "R3 low counts");

        // R4 overflow, 1-bit prescaler
        bus_write(2'd0, 8'h20, 1'b0);
        bus_write(2'd3, 8'hFF, 1'b0);
        bus_write(2'd2, 8'h01, 1'b0);
        expect_val(4, 8'h00, "R4 no ovf yet");
        ticks(1);
        expect_val(4, 8'h01, "R4 ovf set");
        expect_val(1, 8'h09, "R4 ovf in mode bit3");
        expect_val(3, 8'h00, "R4 high zero");
        expect_val(2, 8'h00, "R4 low zero");
        ticks(3);
        expect_val(4, 8'h01, "R8 sticky");
        bus_write(2'd1, 8'h09, 1'b0);
        expect_val(4, 8'h01, "R8 write one keeps");
        bus_write(2'd1, 8'h01, 1'b0);
        expect_val(4, 8'h00, "R8 cleared");

        // R4 with 8-bit prescaler
        bus_write(2'd0, 8'h27, 1'b0);
        bus_write(2'd3, 8'hFF, 1'b0);
        bus_write(2'd2, 8'hFE, 1'b0);
        ticks(1);
        expect_val(4, 8'h00, "R4 16-bit not yet");
        expect_val(2, 8'hFF, "R4 16-bit low");
        ticks(1);
        expect_val(4, 8'h01, "R4 16-bit ovf");
        expect_val(3, 8'h00, "R4 16-bit high");

        // R8 set wins over clear
        bus_write(2'd1, 8'h01, 1'b0);
        bus_write(2'd0, 8'h20, 1'b0);
        bus_write(2'd3, 8'hFF, 1'b0);
        bus_write(2'd2, 8'h01, 1'b0);
        bus_write(2'd1, 8'h01, 1'b1);
        expect_val(4, 8'h01, "R8 set wins");
        bus_write(2'd1, 8'h01, 1'b0);
        expect_val(4, 8'h00, "R8 cleared again");

        // R9 write wins over increment
        bus_write(2'd0, 8'h24, 1'b0);
        bus_write(2'd2, 8'h10, 1'b0);
        bus_write(2'd2, 8'h05, 1'b1);
        expect_val(2, 8'h05, "R9 low write wins");
        bus_write(2'd3, 8'h33, 1'b1);
        expect_val(3, 8'h33, "R9 high write");
        expect_val(2, 8'h06, "R9 low counted");

        // R5 gate
        bus_write(2'd1, 8'h03, 1'b0);
        bus_write(2'd2, 8'h00, 1'b0);
        gate_pin = 1'b0;
        ticks(5);
        expect_val(2, 8'h00, "R5 gate blocks");
        gate_pin = 1'b1;
        ticks(5);
        expect_val(2, 8'h05, "R5 gate passes");
        gate_pin = 1'b0;

        // R7 counter mode
        bus_write(2'd1, 8'h05, 1'b0);
        bus_write(2'd2, 8'h00, 1'b0);
        ticks(4);
        expect_val(2, 8'h00, "R7 tick ignored");
        event_pulses(3);
        expect_val(2, 8'h03, "R7 event edges");
        expect_val(1, 8'h05, "R7 mode read");

        // R11 channel field selection
        bus_write(2'd0, 8'h64, 1'b0);
        expect_val(5, 8'h01, "R11 pwm on");
        bus_write(2'd0, 8'hA4, 1'b0);
        expect_val(5, 8'h00, "R11 other pwm ignored");
        bus_write(2'd0, 8'h38, 1'b0);
        bus_write(2'd1, 8'h01, 1'b0);
        bus_write(2'd2, 8'h00, 1'b0);
        bus_write(2'd3, 8'h00, 1'b0);
        ticks(2);
        expect_val(2, 8'h00, "R11 own width used");
        expect_val(3, 8'h01, "R11 carry at width 1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule